// File: doc/BRIEF.md
# Software-Interrupt Inter-Processor Interrupt Controller

This block lets any of up to seven harts (four by default) raise an inter-processor interrupt on any other hart, itself included, through plain register writes. Every ordered (sender, target) pair is its own interrupt source. Each source has a pending bit in a shared write-one-to-set array, a priority register, and an in-flight flag. Each target hart has its own context: an enable mask that selects which sources reach it, a claim register, and one level-sensitive interrupt line.

A target services an interrupt in three steps. It reads its claim register, which returns the winning source ID and atomically moves that source from pending to in flight. It handles the request. It then writes the same ID back to the claim register, and the source can be delivered again. A source whose priority is zero never reaches any target.

The source ID of the pair (sender X, target Y) is 1 + 8·X + Y. ID 0 means "no interrupt". The register bus is a single-cycle 32-bit port with a byte address. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read strobe.

Top module: `ipi_ctrl`

## Requirements
- R1: The pending array is write-one-to-set. A 1 bit in the write data sets the matching pending bit. A 0 bit leaves it unchanged, so rewriting a word with zeros never clears a pending request.
- R2: Pending word w is at byte offset 0x1000 + 4·w, with w = X/4. Inside the word, sender X owns bits 8·(X%4)+7 down to 8·(X%4). Bit Y of that byte is the request from X to Y. Bit b of word w is therefore source ID 1 + 32·w + b. Reading the word returns the current pending bits.
- R3: The priority of source ID k is held at byte offset 4·k in the low PRIO_W bits, and upper bits read as zero. All priorities reset to 0.
- R4: Target T has two enable words, at 0x2000 + 0x80·T and at that address + 4. Bit b of the first word enables ID b, and bit b of the second word enables ID 32 + b. Both words reset to 0.
- R5: A read of target T's claim register (0x200004 + 0x1000·T) returns the ID of the winning eligible source for T, or 0 when none is eligible. A nonzero return clears that source's pending bit and marks it in flight. A source is eligible when it is pending, enabled for T, has nonzero priority and is not in flight.
- R6: Among eligible sources, the highest priority wins and equal priorities go to the lowest ID. A source with priority 0 is never returned and never raises a line.
- R7: An in-flight source cannot be claimed again, even if its pending bit is set again, until it is completed.
- R8: Writing an ID to target T's claim register completes it only if that ID is in flight and enabled for T. Any other completion write is ignored.
- R9: irq[T] is high exactly while target T has at least one eligible source. The line follows a register write from the clock edge that performs the write.
- R10: Sources, pending bits, enable words and contexts that involve a hart at or beyond N_HARTS read as zero and ignore writes.
- R11: Read data is registered. It is zero after reset, and a read of an unmapped or misaligned address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 22 | Byte address of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; claim reads have side effects |
| rdata | output | 32 | Registered read data, valid the cycle after rd_en |
| irq | output | N_HARTS | Per-target interrupt request level |

## Verification
A wrong pending or in-flight bit shows on irq in the same cycle as the write or claim that caused it, and on the next claim read one cycle later. An interrupt that is lost, duplicated or stuck therefore shows within one transaction. Arbitration faults show only as a wrong claim order. For that reason the bench loads several sources with mixed and equal priorities and drains them one claim at a time. Masking faults for harts that are not present show as nonzero read data from regions that must stay zero.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int ADDR_W   = 22;
  localparam int DATA_W   = 32;
  localparam int REGION_W = 8;
  localparam int ID_NUM   = 64;
  localparam int ID_W     = $clog2(ID_NUM);
  localparam int TGT_MAX  = 8;
  localparam int TGT_W    = $clog2(TGT_MAX);

  localparam logic [9:0] PEND_PAGE  = 10'h001;
  localparam logic [9:0] EN_PAGE    = 10'h002;
  localparam logic [6:0] CTX_TOP    = 7'b1000000;
  localparam logic [11:0] CLAIM_OFS = 12'h004;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_EN,
    RG_CLAIM
  } rgn_e;

  typedef struct packed {
    rgn_e             kind;
    logic [ID_W-1:0]  id;
    logic [TGT_W-1:0] tgt;
    logic             word;
  } dec_t;

  // Source k = 1 + REGION_W*sender + target
  function automatic logic id_valid(int id, int n);
    if (id < 1 || id >= ID_NUM) return 1'b0;
    return (((id - 1) / REGION_W) < n) && (((id - 1) % REGION_W) < n);
  endfunction

  function automatic logic [ID_NUM-1:0] valid_mask(int n);
    logic [ID_NUM-1:0] m;
    for (int i = 0; i < ID_NUM; i++) m[i] = id_valid(i, n);
    return m;
  endfunction

  // Pending word w bit b maps to source 1 + 32*w + b
  function automatic logic [ID_NUM-1:0] pend_expand(logic w, logic [DATA_W-1:0] d);
    logic [ID_NUM+DATA_W-1:0] t;
    t = {{ID_NUM{1'b0}}, d} << (1 + DATA_W * int'(w));
    return t[ID_NUM-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] pend_extract(logic w, logic [ID_NUM-1:0] v);
    logic [ID_NUM-1:0] t;
    t = v >> (1 + DATA_W * int'(w));
    return t[DATA_W-1:0];
  endfunction

  function automatic dec_t decode(logic [ADDR_W-1:0] a);
    dec_t d;
    d = '0;
    d.kind = RG_NONE;
    if (a[1:0] == 2'b00) begin
      if (a[21:8] == '0) begin
        d.kind = RG_PRIO;
        d.id   = a[7:2];
      end else if (a[21:12] == PEND_PAGE && a[11:3] == '0) begin
        d.kind = RG_PEND;
        d.word = a[2];
      end else if (a[21:12] == EN_PAGE && a[11:10] == '0 && a[6:3] == '0) begin
        d.kind = RG_EN;
        d.tgt  = a[9:7];
        d.word = a[2];
      end else if (a[21:15] == CTX_TOP && a[11:0] == CLAIM_OFS) begin
        d.kind = RG_CLAIM;
        d.tgt  = a[14:12];
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/ipi_cfg_regs.sv
module ipi_cfg_regs
  import ipi_pkg::*;
#(
  parameter int N_HARTS = 4,
  parameter int PRIO_W  = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 prio_we,
  input  logic [ID_W-1:0]                      prio_id,
  input  logic [PRIO_W-1:0]                    prio_val,
  input  logic                                 en_we,
  input  logic [TGT_W-1:0]                     en_tgt,
  input  logic                                 en_word,
  input  logic [DATA_W-1:0]                    en_val,
  output logic [ID_NUM-1:0][PRIO_W-1:0]        prio,
  output logic [TGT_MAX-1:0][ID_NUM-1:0]       en_mat
);
  localparam logic [ID_NUM-1:0] VMASK = valid_mask(N_HARTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio <= '0;
    end else if (prio_we && VMASK[prio_id]) begin
      prio[prio_id] <= prio_val;
    end
  end

  for (genvar t = 0; t < TGT_MAX; t++) begin : g_row
    if (t < N_HARTS) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          en_mat[t] <= '0;
        end else if (en_we && en_tgt == TGT_W'(t)) begin
          if (en_word) en_mat[t][ID_NUM-1:DATA_W] <= en_val & VMASK[ID_NUM-1:DATA_W];
          else         en_mat[t][DATA_W-1:0]      <= en_val & VMASK[DATA_W-1:0];
        end
      end
      AST_EN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mat[t] & ~VMASK) == '0); // R10
    end else begin : g_dead
      assign en_mat[t] = '0;
    end
  end
endmodule

// File: rtl/ipi_pending.sv
module ipi_pending
  import ipi_pkg::*;
#(
  parameter int N_HARTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_we,
  input  logic               set_word,
  input  logic [DATA_W-1:0]  set_data,
  input  logic               clr_fire,
  input  logic [ID_W-1:0]    clr_id,
  input  logic               done_fire,
  input  logic [ID_W-1:0]    done_id,
  output logic [ID_NUM-1:0]  pend,
  output logic [ID_NUM-1:0]  busy
);
  localparam logic [ID_NUM-1:0] VMASK = valid_mask(N_HARTS);

  logic [ID_NUM-1:0] set_vec, clr_vec, done_vec;

  always_comb begin
    set_vec  = set_we ? (pend_expand(set_word, set_data) & VMASK) : '0;
    clr_vec  = (clr_fire && clr_id != '0) ? (ID_NUM'(1) << clr_id) : '0;
    done_vec = done_fire ? (ID_NUM'(1) << done_id) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      busy <= '0;
    end else begin
      pend <= (pend & ~clr_vec) | set_vec;
      busy <= (busy & ~done_vec) | clr_vec;
    end
  end

  for (genvar i = 1; i < ID_NUM; i++) begin : g_chk
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] && !clr_vec[i] |=> pend[i]); // R1
  end

  AST_CLAIM_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire && clr_id != '0 |=> busy[$past(clr_id)]); // R5
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend | busy) & ~VMASK) == '0); // R10
endmodule

// File: rtl/ipi_arbiter.sv
module ipi_arbiter
  import ipi_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ID_NUM-1:0]             pend,
  input  logic [ID_NUM-1:0]             busy,
  input  logic [ID_NUM-1:0]             en,
  input  logic [ID_NUM-1:0][PRIO_W-1:0] prio,
  output logic [ID_W-1:0]               best_id,
  output logic [PRIO_W-1:0]             best_prio
);
  logic [ID_NUM-1:0] elig;

  always_comb begin
    for (int i = 0; i < ID_NUM; i++) elig[i] = pend[i] && !busy[i] && en[i] && (prio[i] != '0);
    best_id   = '0;
    best_prio = '0;
    // strict compare keeps the lowest ID among equals
    for (int i = 1; i < ID_NUM; i++) begin
      if (elig[i] && prio[i] > best_prio) begin
        best_id   = ID_W'(i);
        best_prio = prio[i];
      end
    end
  end

  for (genvar i = 1; i < ID_NUM; i++) begin : g_chk
    AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      elig[i] |-> prio[i] <= best_prio); // R6
    AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      elig[i] && prio[i] == best_prio |-> best_id <= ID_W'(i)); // R6
  end

  AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    best_id != '0 |-> pend[best_id] && !busy[best_id] && prio[best_id] != '0); // R7
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int N_HARTS = 4,
  parameter int PRIO_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [21:0]          addr,
  input  logic [31:0]          wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [31:0]          rdata,
  output logic [N_HARTS-1:0]   irq
);
  if (N_HARTS < 1 || N_HARTS > 7) begin : g_bad_cfg
    $error("ipi_ctrl: N_HARTS must lie in 1..7");
  end

  dec_t                          dec;
  logic                          tgt_ok;
  logic [ID_NUM-1:0][PRIO_W-1:0] prio;
  logic [TGT_MAX-1:0][ID_NUM-1:0] en_mat;
  logic [ID_NUM-1:0]             pend, busy;
  logic [TGT_MAX-1:0][ID_W-1:0]  win_id;
  logic                          claim_fire, done_fire;
  logic [ID_W-1:0]               claim_id, done_id;
  logic                          done_in_range;
  logic [DATA_W-1:0]             rd_mux;

  assign dec    = decode(addr);
  assign tgt_ok = int'(dec.tgt) < N_HARTS;

  // events brought out for the checks
  assign claim_fire    = rd_en && dec.kind == RG_CLAIM && tgt_ok;
  assign claim_id      = win_id[dec.tgt];
  assign done_in_range = wdata < DATA_W'(ID_NUM);
  assign done_id       = wdata[ID_W-1:0];
  assign done_fire     = wr_en && dec.kind == RG_CLAIM && tgt_ok && done_in_range
                         && busy[done_id] && en_mat[dec.tgt][done_id];

  ipi_cfg_regs #(.N_HARTS(N_HARTS), .PRIO_W(PRIO_W)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .prio_we  (wr_en && dec.kind == RG_PRIO),
    .prio_id  (dec.id),
    .prio_val (wdata[PRIO_W-1:0]),
    .en_we    (wr_en && dec.kind == RG_EN),
    .en_tgt   (dec.tgt),
    .en_word  (dec.word),
    .en_val   (wdata),
    .prio     (prio),
    .en_mat   (en_mat)
  );

  ipi_pending #(.N_HARTS(N_HARTS)) i_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_we    (wr_en && dec.kind == RG_PEND),
    .set_word  (dec.word),
    .set_data  (wdata),
    .clr_fire  (claim_fire),
    .clr_id    (claim_id),
    .done_fire (done_fire),
    .done_id   (done_id),
    .pend      (pend),
    .busy      (busy)
  );

  for (genvar t = 0; t < TGT_MAX; t++) begin : g_tgt
    if (t < N_HARTS) begin : g_live
      logic [PRIO_W-1:0] top_prio;
      ipi_arbiter #(.PRIO_W(PRIO_W)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .busy      (busy),
        .en        (en_mat[t]),
        .prio      (prio),
        .best_id   (win_id[t]),
        .best_prio (top_prio)
      );
      assign irq[t] = win_id[t] != '0;
      AST_IRQ_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        irq[t] |-> (pend & ~busy & en_mat[t]) != '0); // R9
    end else begin : g_dead
      assign win_id[t] = '0;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (dec.kind)
      RG_PRIO:  rd_mux = DATA_W'(prio[dec.id]);
      RG_PEND:  rd_mux = pend_extract(dec.word, pend);
      RG_EN:    if (tgt_ok) rd_mux = dec.word ? en_mat[dec.tgt][ID_NUM-1:DATA_W]
                                              : en_mat[dec.tgt][DATA_W-1:0];
      RG_CLAIM: if (tgt_ok) rd_mux = DATA_W'(claim_id);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_BAD_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && dec.kind == RG_CLAIM && !done_fire |=> $stable(busy)); // R8
  AST_NO_DOUBLE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire && claim_id != '0 |-> !busy[claim_id]); // R7
endmodule

// File: tb/test_ipi_ctrl.sv
`timescale 1ns/1ps
module test_ipi_ctrl;
  localparam int NH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [NH-1:0] irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ipi_ctrl #(.N_HARTS(NH), .PRIO_W(3)) i_ipi_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  function automatic int sid(int x, int y);
    return 1 + 8 * x + y;
  endfunction
  function automatic logic [21:0] a_prio(int id);  return 22'(4 * id); endfunction
  function automatic logic [21:0] a_pend(int w);   return 22'(32'h1000 + 4 * w); endfunction
  function automatic logic [21:0] a_en(int t, int w); return 22'(32'h2000 + 32'h80 * t + 4 * w); endfunction
  function automatic logic [21:0] a_claim(int t);  return 22'(32'h200004 + 32'h1000 * t); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [21:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: queue the expected value, then issue the read
  task automatic rd_exp(logic [21:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: registered read data is compared half a cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9 irq after reset", 32'(irq), 32'h0);
    rd_exp(a_pend(0), 32'h0, "R11 pending after reset");
    rd_exp(a_claim(0), 32'h0, "R5 empty claim");
    rd_exp(22'h3000, 32'h0, "R11 unmapped read");

    for (int x = 0; x < NH; x++)
      for (int y = 0; y < NH; y++) wr(a_prio(sid(x, y)), 32'h1);
    wr(a_prio(1), 32'h1234_5677);
    rd_exp(a_prio(1), 32'h7, "R3 priority field width");
    wr(a_prio(1), 32'h1);
    rd_exp(a_prio(sid(1, 2)), 32'h1, "R3 priority readback");
    wr(a_prio(5), 32'h3);
    rd_exp(a_prio(5), 32'h0, "R10 priority of absent target");

    for (int t = 0; t < NH; t++) wr(a_en(t, 0), 32'h0202_0202 << t);
    rd_exp(a_en(1, 0), 32'h0404_0404, "R4 enable readback");
    wr(a_en(1, 1), 32'hFFFF_FFFF);
    rd_exp(a_en(1, 1), 32'h0, "R10 enable upper word absent ids");
    wr(a_en(5, 0), 32'hFFFF_FFFF);
    rd_exp(a_en(5, 0), 32'h0, "R10 enable of absent target");

    // hart 1 -> hart 2: byte 1, bit 2
    wr(a_pend(0), 32'h0000_0400);
    rd_exp(a_pend(0), 32'h0000_0400, "R2 pending layout");
    check("R9 irq raised for target 2", 32'(irq), 32'h4);
    wr(a_pend(0), 32'h0);
    rd_exp(a_pend(0), 32'h0000_0400, "R1 zero write keeps pending");
    rd_exp(a_claim(2), 32'(sid(1, 2)), "R5 claim returns id");
    check("R9 irq drops after claim", 32'(irq), 32'h0);
    rd_exp(a_pend(0), 32'h0, "R5 claim clears pending");

    wr(a_pend(0), 32'h0000_0400);
    rd_exp(a_pend(0), 32'h0000_0400, "R7 re-set while in flight");
    check("R7 no irq while in flight", 32'(irq), 32'h0);
    rd_exp(a_claim(2), 32'h0, "R7 no second claim");
    wr(a_claim(2), 32'h3);
    rd_exp(a_claim(2), 32'h0, "R8 stray completion ignored");
    wr(a_claim(1), 32'(sid(1, 2)));
    check("R8 completion on wrong target ignored", 32'(irq), 32'h0);
    wr(a_claim(2), 32'(sid(1, 2)));
    check("R8 completion re-arms irq", 32'(irq), 32'h4);
    rd_exp(a_claim(2), 32'(sid(1, 2)), "R8 redelivery after completion");
    wr(a_claim(2), 32'(sid(1, 2)));

    // priority ordering towards target 0
    wr(a_prio(sid(1, 0)), 32'h2);
    wr(a_prio(sid(2, 0)), 32'h3);
    wr(a_prio(sid(3, 0)), 32'h3);
    wr(a_pend(0), 32'h0101_0100);
    check("R9 irq for target 0", 32'(irq), 32'h1);
    rd_exp(a_claim(0), 32'(sid(2, 0)), "R6 highest priority, lowest id first");
    rd_exp(a_claim(0), 32'(sid(3, 0)), "R6 equal priority next");
    rd_exp(a_claim(0), 32'(sid(1, 0)), "R6 lower priority last");
    rd_exp(a_claim(0), 32'h0, "R5 drained claim");
    wr(a_claim(0), 32'(sid(2, 0)));
    wr(a_claim(0), 32'(sid(3, 0)));
    wr(a_claim(0), 32'(sid(1, 0)));

    // priority zero blocks delivery
    wr(a_prio(sid(1, 0)), 32'h0);
    wr(a_pend(0), 32'h0000_0100);
    check("R6 zero priority keeps irq low", 32'(irq), 32'h0);
    rd_exp(a_claim(0), 32'h0, "R6 zero priority not claimed");
    wr(a_prio(sid(1, 0)), 32'h1);
    check("R9 irq follows priority change", 32'(irq), 32'h1);
    rd_exp(a_claim(0), 32'(sid(1, 0)), "R6 delivered once enabled by priority");
    wr(a_claim(0), 32'(sid(1, 0)));

    // harts beyond the configured count
    wr(a_pend(1), 32'hFFFF_FFFF);
    rd_exp(a_pend(1), 32'h0, "R10 pending word of absent senders");
    wr(a_pend(0), 32'h0000_0010);
    rd_exp(a_pend(0), 32'h0, "R10 pending bit for absent target");
    check("R10 no irq from absent harts", 32'(irq), 32'h0);
    rd_exp(a_claim(4), 32'h0, "R10 claim of absent context");
    rd_exp(22'h1002, 32'h0, "R11 misaligned read");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule